// File: doc/BRIEF.md
# Symbol Parity Encoder over GF(2^M)

This block sits after the bit interleaver in the optional concatenated coding path. It takes a serial stream of coded bits and packs them into symbols of M bits each, one bit per accepted handshake. The first bit of a tuple becomes its most significant bit. Each tuple is an element of GF(2^M). Eight such message symbols form a block. After the eighth, the encoder emits a ninth symbol that is their field sum. Addition in GF(2^M) is a plain bitwise XOR, so the ninth symbol is the XOR of the eight. Every output symbol is a data symbol in the alphabet 0 to 2^M-1.

The symbol width is chosen at run time through `mode_sel`. It may only change while the encoder is idle: no partial tuple is held and no block is half sent. Both stream edges use valid/ready handshakes. A transfer takes place on a rising clock edge where valid and ready are both high. A presented output symbol stays stable until it is taken. While the parity symbol waits for its slot, no new tuple enters the block. Input bits keep arriving only until one complete tuple is held; `in_ready` then falls until that tuple can move on.

Top module: `sym_parity_enc`

## Requirements
- R1: While and directly after reset, `out_valid` is 0 and `in_ready` is 1.
- R2: `mode_sel` selects M: 0 gives M=1, 1 gives M=2, 2 gives M=3, 3 gives M=5. The first bit accepted for a tuple lands in bit M-1 of the symbol, and the last bit lands in bit 0.
- R3: Each block's eight message symbols leave in the same order as their tuples were completed.
- R4: The ninth symbol of every block is the bitwise XOR of that block's eight message symbols.
- R5: `out_last` is 1 on the ninth symbol of each block and 0 on every message symbol.
- R6: Bits M and above of `out_sym` are always 0.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_sym` and `out_last` hold their values on the next cycle.
- R8: A bit is consumed only on a cycle where `in_valid` and `in_ready` are both 1. Idle gaps in `in_valid` do not change the coded result.
- R9: If M is changed while the encoder is idle, the next block uses the new M. Nothing carries over from the previous frame.
- R10: The parity for each block starts from zero, so earlier blocks never affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Symbol width select (see R2) |
| in_valid | input | 1 | Input bit offered |
| in_ready | output | 1 | Encoder can take a bit |
| in_bit | input | 1 | Serial input bit |
| out_valid | output | 1 | Output symbol presented |
| out_ready | input | 1 | Downstream takes the symbol |
| out_sym | output | MAX_M | Coded data symbol, right-aligned |
| out_last | output | 1 | Marks the parity symbol of a block |

## Verification
The bench and checks watch for four kinds of faults, each visible at the ports:
- **Wrong fill count or bit order in the packer:** a corrupted message symbol appears on the first tuple emitted in the affected mode.
- **Faulty parity accumulator:** a parity accumulator that is not cleared, or that misses a term, shows up on the ninth symbol of the block. If the fault is a missed clear, it shows on the second block.
- **Wrong block index:** an index that is off by one moves `out_last` within the first block.
- **Bad output register:** a register that updates during back-pressure changes the symbol while the symbol is still waiting to be taken.

// File: rtl/spc_pkg.sv
package spc_pkg;

  typedef enum logic [1:0] {
    MODE_W1 = 2'd0,
    MODE_W2 = 2'd1,
    MODE_W3 = 2'd2,
    MODE_W5 = 2'd3
  } width_mode_e;

  typedef enum logic {
    PH_MSG = 1'b0,
    PH_PAR = 1'b1
  } phase_e;

  // Symbol width in bits for a given mode code.
  function automatic logic [2:0] tuple_width(input logic [1:0] code);
    case (width_mode_e'(code))
      MODE_W1: return 3'd1;
      MODE_W2: return 3'd2;
      MODE_W3: return 3'd3;
      default: return 3'd5;
    endcase
  endfunction

endpackage

// File: rtl/spc_packer.sv
// Serial-to-tuple packer: first accepted bit ends up as the tuple MSB.
module spc_packer #(
  parameter int MAX_M = 5,
  localparam int CW = $clog2(MAX_M + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    m_width,
  input  logic             in_valid,
  input  logic             in_bit,
  output logic             in_ready,
  output logic             tup_valid,
  input  logic             tup_ready,
  output logic [MAX_M-1:0] tup_data
);

  logic [MAX_M-1:0] shreg;
  logic [CW-1:0]    fill;
  logic             take_bit;
  logic             pop;

  assign tup_valid = (fill == m_width);
  assign in_ready  = !tup_valid || tup_ready;
  assign take_bit  = in_valid && in_ready;
  assign pop       = tup_valid && tup_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      fill  <= '0;
    end else if (take_bit) begin
      shreg <= {shreg[MAX_M-2:0], in_bit};
      fill  <= pop ? CW'(1) : CW'(fill + 1'b1);
    end else if (pop) begin
      fill <= '0;
    end
  end

  // Keep only the low M bits; older shifted bits are stale.
  for (genvar i = 0; i < MAX_M; i++) begin : g_keep
    assign tup_data[i] = shreg[i] & (m_width > CW'(i));
  end

endmodule

// File: rtl/spc_blocker.sv
// Block framer: passes message symbols, then emits their XOR as parity.
module spc_blocker #(
  parameter int MAX_M   = 5,
  parameter int BLK_LEN = 8,
  localparam int IW = $clog2(BLK_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tup_valid,
  input  logic [MAX_M-1:0] tup_data,
  output logic             tup_ready,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [MAX_M-1:0] out_sym,
  output logic             out_last
);
  import spc_pkg::*;

  phase_e           phase;
  logic [IW-1:0]    idx;
  logic [MAX_M-1:0] acc;
  logic             slot_free;

  assign slot_free = !out_valid || out_ready;
  assign tup_ready = (phase == PH_MSG) && slot_free;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_MSG;
      idx       <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_sym   <= '0;
      out_last  <= 1'b0;
    end else if (slot_free) begin
      if (phase == PH_MSG && tup_valid) begin
        out_valid <= 1'b1;
        out_sym   <= tup_data;
        out_last  <= 1'b0;
        acc       <= acc ^ tup_data;
        if (idx == IW'(BLK_LEN - 1)) begin
          idx   <= '0;
          phase <= PH_PAR;
        end else begin
          idx <= IW'(idx + 1'b1);
        end
      end else if (phase == PH_PAR) begin
        out_valid <= 1'b1;
        out_sym   <= acc;
        out_last  <= 1'b1;
        acc       <= '0;
        phase     <= PH_MSG;
      end else begin
        out_valid <= 1'b0;
        out_last  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sym_parity_enc.sv
module sym_parity_enc #(
  parameter int MAX_M   = 5,
  parameter int BLK_LEN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_bit,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [MAX_M-1:0] out_sym,
  output logic             out_last
);
  localparam int CW = $clog2(MAX_M + 1);

  logic [CW-1:0]    m_width;
  logic             tup_valid;
  logic             tup_ready;
  logic [MAX_M-1:0] tup_data;

  assign m_width = CW'(spc_pkg::tuple_width(mode_sel));

  spc_packer #(.MAX_M(MAX_M)) u_pack (
    .clk(clk), .rst_n(rst_n), .m_width(m_width),
    .in_valid(in_valid), .in_bit(in_bit), .in_ready(in_ready),
    .tup_valid(tup_valid), .tup_ready(tup_ready), .tup_data(tup_data)
  );

  spc_blocker #(.MAX_M(MAX_M), .BLK_LEN(BLK_LEN)) u_blk (
    .clk(clk), .rst_n(rst_n),
    .tup_valid(tup_valid), .tup_data(tup_data), .tup_ready(tup_ready),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_sym(out_sym), .out_last(out_last)
  );

endmodule

// File: rtl/spc_enc_chk.sv
module spc_enc_chk #(
  parameter int MAX_M   = 5,
  parameter int BLK_LEN = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_sel,
  input logic             out_valid,
  input logic             out_ready,
  input logic [MAX_M-1:0] out_sym,
  input logic             out_last
);
  logic [7:0]       pos;
  logic [MAX_M-1:0] run_xor;
  logic [MAX_M-1:0] mask;

  always_comb begin
    for (int i = 0; i < MAX_M; i++) mask[i] = (i < int'(spc_pkg::tuple_width(mode_sel)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos     <= '0;
      run_xor <= '0;
    end else if (out_valid && out_ready) begin
      if (pos == 8'(BLK_LEN)) begin
        pos     <= '0;
        run_xor <= '0;
      end else begin
        pos     <= pos + 8'd1;
        run_xor <= run_xor ^ out_sym;
      end
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_sym) && $stable(out_last));

  p_last_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_last == (pos == 8'(BLK_LEN))));

  p_parity_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && pos == 8'(BLK_LEN) |-> out_sym == run_xor);

  p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sym & ~mask) == '0);

endmodule

bind sym_parity_enc spc_enc_chk #(.MAX_M(MAX_M), .BLK_LEN(BLK_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .out_valid(out_valid),
  .out_ready(out_ready), .out_sym(out_sym), .out_last(out_last)
);

// File: tb/sim_sym_parity_enc.sv
module sim_sym_parity_enc;
  localparam int MAX_M = 5;
  localparam int BLK   = 8;
  localparam int NBLK  = 4;
  localparam int NTUP  = BLK * NBLK;
  localparam int NSYM  = (BLK + 1) * NBLK;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n = 1'b0;
  logic [1:0]       mode_sel = 2'd0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic             in_bit = 1'b0;
  logic             out_valid;
  logic             out_ready = 1'b0;
  logic [MAX_M-1:0] out_sym;
  logic             out_last;

  int n_cmp = 0;
  int n_bad = 0;
  int got_n;
  logic [MAX_M-1:0] exp_tup [NTUP];
  logic [MAX_M-1:0] got_sym [NSYM];
  logic             got_last [NSYM];

  sym_parity_enc #(.MAX_M(MAX_M), .BLK_LEN(BLK)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_sym(out_sym), .out_last(out_last)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R8: bits offered with idle gaps every gap_mod cycles.
  task automatic drive_bits(input int m, input int gap_mod);
    int gc = 0;
    for (int k = 0; k < NTUP; k++) begin
      for (int b = m - 1; b >= 0; b--) begin
        forever begin
          @(negedge clk);
          gc++;
          in_valid = (gap_mod == 0) || (gc % gap_mod != 0);
          in_bit   = exp_tup[k][b];
          #1;
          if (in_valid && in_ready) break;
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // R7: back-pressure every stall_mod cycles, held values compared.
  task automatic collect(input int stall_mod);
    int sc = 0;
    bit held = 1'b0;
    logic [MAX_M-1:0] h_sym = '0;
    logic h_last = 1'b0;
    got_n = 0;
    while (got_n < NSYM) begin
      @(negedge clk);
      sc++;
      out_ready = (stall_mod == 0) || (sc % stall_mod != 0);
      #1;
      if (held) begin
        check(out_valid && out_sym == h_sym && out_last == h_last,
              "R7 hold", int'(out_sym), int'(h_sym));
      end
      held = 1'b0;
      if (out_valid && !out_ready) begin
        held = 1'b1; h_sym = out_sym; h_last = out_last;
      end
      if (out_valid && out_ready) begin
        got_sym[got_n]  = out_sym;
        got_last[got_n] = out_last;
        got_n++;
      end
    end
    @(negedge clk);
    out_ready = 1'b1;
  endtask

  task automatic run_mode(input logic [1:0] code, input int m, input int gap_mod,
                          input int stall_mod);
    mode_sel = code;
    for (int k = 0; k < NTUP; k++) exp_tup[k] = MAX_M'((k * 5 + 3) % (1 << m));
    fork
      drive_bits(m, gap_mod);
      collect(stall_mod);
    join
    for (int s = 0; s < NSYM; s++) begin
      int b = s / (BLK + 1);
      int j = s % (BLK + 1);
      logic [MAX_M-1:0] e = '0;
      if (j < BLK) begin
        e = exp_tup[b * BLK + j];
        check(got_sym[s] == e, "R2/R3 message symbol", int'(got_sym[s]), int'(e));
      end else begin
        for (int q = 0; q < BLK; q++) e ^= exp_tup[b * BLK + q];
        check(got_sym[s] == e, "R4/R10 parity symbol", int'(got_sym[s]), int'(e));
      end
      check(got_last[s] == (j == BLK), "R5 last flag", int'(got_last[s]), int'(j == BLK));
      check((got_sym[s] >> m) == 0, "R6 upper bits", int'(got_sym[s] >> m), 0);
    end
    #1;
    check(!out_valid && in_ready, "R9 idle between frames",
          int'({out_valid, in_ready}), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    #1;
    check(!out_valid, "R1 out_valid in reset", int'(out_valid), 0);
    check(in_ready, "R1 in_ready in reset", int'(in_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    out_ready = 1'b1;
    #1;
    check(!out_valid && in_ready, "R1 after reset", int'({out_valid, in_ready}), 1);
    // R9: mode sequence without reset between frames.
    run_mode(2'd2, 3, 0, 0);
    run_mode(2'd0, 1, 3, 4);
    run_mode(2'd1, 2, 0, 2);
    run_mode(2'd3, 5, 2, 3);
    run_mode(2'd2, 3, 5, 2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule